// File: doc/BRIEF.md
# 10BASE-T Transmit Serializer with Jabber Lockout

This block is the digital half of a 10 Mb/s twisted-pair transmitter. It takes 4-bit nibbles from the MII together with the transmit enable and shifts each nibble out least significant bit first at 10 Mb/s. Every bit becomes a pair of half-bit symbols (Manchester coding), ready for the analog pulse shaper and line driver. A free-running nibble slot timer sets the pace. It returns a one-clock strobe that marks the edge on which the nibble and the enable are sampled.

When no frame is in flight the block sends a short positive link pulse at a fixed interval, so that the far end sees a live link. When a frame ends, the line is held high for two bit times before the driver is released.

A jabber guard measures how long the transmit enable stays high without a break. If the enable stays high too long, the guard switches the driver off and raises a status flag. The lockout holds until the enable has stayed low for a long unbroken interval, nominally half a second. During the lockout both frames and link pulses are suppressed.

Top module: `tenbt_tx`

## Requirements
- R1: While reset is asserted and directly after it, `tx_oe`, `tx_data` and `jabber` are all 0.
- R2: A nibble slot lasts 8 half-bit periods of HALF_CLKS clocks each. When `mii_tx_en` is 1 on a strobe edge, a frame starts or continues and `tx_oe` is 1 for that whole slot.
- R3: Within a slot, `mii_txd[0]` is sent first and `mii_txd[3]` last, two half-bits per bit. A 0 is sent as high then low and a 1 as low then high on `tx_data`.
- R4: `nib_strobe` is 1 for exactly one clock per slot, the last clock of the slot. `mii_txd` and `mii_tx_en` are sampled on the rising edge that ends that clock.
- R5: If `mii_tx_en` is 0 on the strobe edge that follows a data slot, `tx_data` and `tx_oe` stay 1 for four half-bits and then both go to 0. Whenever `tx_oe` is 0, `tx_data` is 0.
- R6: While idle and out of lockout, a link pulse (`tx_data` = `tx_oe` = 1) lasts the last 2·HALF_CLKS clocks of every LINK_PERIOD_CLKS-clock interval. The interval count restarts from reset and from each return to idle.
- R7: After JAB_CLKS consecutive clocks with `mii_tx_en` high, `jabber` becomes 1 and `tx_oe` drops on the same edge.
- R8: While `jabber` is 1, `mii_tx_en` and `mii_txd` are ignored, no link pulse is sent, and `tx_oe` stays 0.
- R9: `jabber` returns to 0 only after UNJAB_CLKS consecutive clocks with `mii_tx_en` low. A single high clock restarts that count.
- R10: After the lockout ends, frames are sent again exactly as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one half-bit lasts HALF_CLKS cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_txd | input | 4 | Transmit nibble from the MAC |
| mii_tx_en | input | 1 | Transmit enable from the MAC |
| nib_strobe | output | 1 | Marks the last clock of a nibble slot (sampling edge follows) |
| tx_data | output | 1 | Manchester line symbol towards the driver |
| tx_oe | output | 1 | Driver enable |
| jabber | output | 1 | Lockout status, high for the whole lockout |

## Verification
The bench builds the block with HALF_CLKS=2, LINK_PERIOD_CLKS=120, JAB_CLKS=200 and UNJAB_CLKS=300. These values replace the millisecond-scale defaults with counts of a few hundred clocks. With them, two link-pulse intervals, a complete jabber entry, an interrupted lockout and its clean exit all fit in a short run. Two clocks per half-bit let the bench see both the first and the last clock of every half-bit symbol, as well as the strobe as a lone pulse.

// File: rtl/tenbt_tx_pkg.sv
package tenbt_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_TAIL = 2'd2
   } tx_state_e;

   localparam int SLOT_HALVES = 8;
   localparam int TAIL_HALVES = 4;
endpackage

// File: rtl/tenbt_halfbit_timer.sv
module tenbt_halfbit_timer #(
   parameter int HALF_CLKS = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       half_tick,
   output logic [2:0] slot
);
   if (HALF_CLKS < 1) begin : g_bad_half
      $error("HALF_CLKS must be at least 1");
   end

   if (HALF_CLKS == 1) begin : g_direct
      assign half_tick = 1'b1;
   end else begin : g_divided
      localparam int DW = $clog2(HALF_CLKS);
      logic [DW-1:0] divc;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            divc <= '0;
         else if (divc == DW'(HALF_CLKS - 1))
            divc <= '0;
         else
            divc <= divc + 1'b1;
      end
      assign half_tick = (divc == DW'(HALF_CLKS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot <= '0;
      else if (half_tick)
         slot <= slot + 1'b1;
   end
endmodule

// File: rtl/tenbt_jabber.sv
module tenbt_jabber #(
   parameter int JAB_CLKS   = 2_000_000,
   parameter int UNJAB_CLKS = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   output logic jabber
);
   localparam int MAXC = (JAB_CLKS > UNJAB_CLKS) ? JAB_CLKS : UNJAB_CLKS;
   localparam int CW   = $clog2(MAXC + 1);

   if (JAB_CLKS < 2 || UNJAB_CLKS < 2) begin : g_bad_limits
      $error("jabber limits must be at least 2 clocks");
   end

   logic [CW-1:0] run_cnt;
   logic          counting;
   logic          at_limit;

   // Normal mode counts enable-high clocks, lockout counts enable-low clocks.
   assign counting = jabber ? !tx_en : tx_en;
   assign at_limit = jabber ? (run_cnt == CW'(UNJAB_CLKS - 1))
                            : (run_cnt == CW'(JAB_CLKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         jabber  <= 1'b0;
      end else if (!counting) begin
         run_cnt <= '0;
      end else if (at_limit) begin
         run_cnt <= '0;
         jabber  <= !jabber;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tenbt_link_pulse.sv
module tenbt_link_pulse #(
   parameter int PERIOD_CLKS = 1_600_000,
   parameter int WIDTH_CLKS  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   output logic pulse
);
   localparam int LW = $clog2(PERIOD_CLKS);

   if (PERIOD_CLKS <= WIDTH_CLKS || WIDTH_CLKS < 1) begin : g_bad_period
      $error("link pulse period must exceed its width");
   end

   logic [LW-1:0] lp_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lp_cnt <= '0;
      else if (!enable)
         lp_cnt <= '0;
      else if (lp_cnt == LW'(PERIOD_CLKS - 1))
         lp_cnt <= '0;
      else
         lp_cnt <= lp_cnt + 1'b1;
   end

   assign pulse = enable && (lp_cnt >= LW'(PERIOD_CLKS - WIDTH_CLKS));
endmodule

// File: rtl/tenbt_tx.sv
module tenbt_tx
   import tenbt_tx_pkg::*;
#(
   parameter int HALF_CLKS        = 5,
   parameter int LINK_PERIOD_CLKS = 1_600_000,
   parameter int JAB_CLKS         = 2_000_000,
   parameter int UNJAB_CLKS       = 50_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] mii_txd,
   input  logic       mii_tx_en,
   output logic       nib_strobe,
   output logic       tx_data,
   output logic       tx_oe,
   output logic       jabber
);
   localparam int PULSE_CLKS = 2 * HALF_CLKS;
   localparam logic [2:0] LAST_SLOT = 3'(SLOT_HALVES - 1);
   localparam logic [2:0] TAIL_END  = 3'(TAIL_HALVES - 1);

   logic       half_tick;
   logic [2:0] slot;
   logic       lp_pulse;
   logic       cur_bit;
   tx_state_e  state;
   logic [3:0] shreg;

   tenbt_halfbit_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_tick (half_tick),
      .slot      (slot)
   );

   tenbt_jabber #(.JAB_CLKS(JAB_CLKS), .UNJAB_CLKS(UNJAB_CLKS)) u_jabber (
      .clk    (clk),
      .rst_n  (rst_n),
      .tx_en  (mii_tx_en),
      .jabber (jabber)
   );

   tenbt_link_pulse #(.PERIOD_CLKS(LINK_PERIOD_CLKS), .WIDTH_CLKS(PULSE_CLKS)) u_link (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (state == ST_IDLE && !jabber),
      .pulse  (lp_pulse)
   );

   assign nib_strobe = half_tick && (slot == LAST_SLOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         shreg <= '0;
      end else if (jabber) begin
         state <= ST_IDLE;
      end else if (nib_strobe) begin
         if (mii_tx_en) begin
            state <= ST_DATA;
            shreg <= mii_txd;
         end else if (state == ST_DATA) begin
            state <= ST_TAIL;
         end
      end else if (state == ST_TAIL && half_tick && slot == TAIL_END) begin
         state <= ST_IDLE;
      end
   end

   // Bit index comes from the upper slot bits, half-bit phase from bit 0.
   assign cur_bit = shreg[slot[2:1]];

   always_comb begin
      tx_data = 1'b0;
      tx_oe   = 1'b0;
      if (!jabber) begin
         case (state)
            ST_DATA: begin
               tx_oe   = 1'b1;
               tx_data = slot[0] ? cur_bit : !cur_bit;
            end
            ST_TAIL: begin
               tx_oe   = 1'b1;
               tx_data = 1'b1;
            end
            default: begin
               tx_oe   = lp_pulse;
               tx_data = lp_pulse;
            end
         endcase
      end
   end
endmodule

// File: rtl/tenbt_tx_chk.sv
module tenbt_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mii_tx_en,
   input logic       nib_strobe,
   input logic       tx_data,
   input logic       tx_oe,
   input logic       jabber
);
   // R5: a released driver always carries a low symbol
   a_r5_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> !tx_data);

   // R7 / R8: lockout keeps the driver off
   a_r7_lockout_silent: assert property (@(posedge clk) disable iff (!rst_n)
      jabber |-> !tx_oe);

   // R7: lockout is entered only from a high enable
   a_r7_entry_from_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jabber) |-> $past(mii_tx_en));

   // R9: lockout is left only from a low enable
   a_r9_exit_from_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(jabber) |-> !$past(mii_tx_en));

   // R4: the strobe is a single-clock pulse
   a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      nib_strobe |=> !nib_strobe);
endmodule

bind tenbt_tx tenbt_tx_chk u_tenbt_tx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mii_tx_en  (mii_tx_en),
   .nib_strobe (nib_strobe),
   .tx_data    (tx_data),
   .tx_oe      (tx_oe),
   .jabber     (jabber)
);

// File: tb/tenbt_tx_bench.sv
module tenbt_tx_bench;
   localparam int HALF  = 2;
   localparam int LINKP = 120;
   localparam int JABC  = 200;
   localparam int UNJC  = 300;
   localparam int SLOTC = 8 * HALF;
   localparam int NFR   = 5;
   localparam logic [15:0] FRAMES [NFR] = '{16'h5A3C, 16'hF00F, 16'h0000, 16'hFFFF, 16'h1248};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mii_txd = 4'h0;
   logic       mii_tx_en = 1'b0;
   logic       nib_strobe, tx_data, tx_oe, jabber;
   int         total = 0;
   int         bad = 0;

   always #2 clk = !clk;

   tenbt_tx #(
      .HALF_CLKS(HALF), .LINK_PERIOD_CLKS(LINKP), .JAB_CLKS(JABC), .UNJAB_CLKS(UNJC)
   ) u_tenbt_tx (
      .clk(clk), .rst_n(rst_n), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
      .nib_strobe(nib_strobe), .tx_data(tx_data), .tx_oe(tx_oe), .jabber(jabber)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_strobe();
      do @(negedge clk); while (!nib_strobe);
   endtask

   task automatic run_frame(input logic [15:0] nibs, input int n, input string tag);
      wait_strobe();
      mii_txd   = nibs[3:0];
      mii_tx_en = 1'b1;
      for (int i = 0; i < n; i++) begin
         for (int j = 0; j < SLOTC; j++) begin
            int   h;
            logic b;
            @(negedge clk);
            h = j / HALF;
            b = nibs[i*4 + h/2];
            check({"R3 data ", tag}, tx_data, (h % 2) ? b : !b);
            check({"R2 oe ", tag}, tx_oe, 1);
            check({"R4 strobe ", tag}, nib_strobe, (j == SLOTC - 1));
            if (j == SLOTC - 1) begin
               if (i + 1 < n) mii_txd = nibs[(i+1)*4 +: 4];
               else mii_tx_en = 1'b0;
            end
         end
      end
      for (int j = 0; j < 4 * HALF; j++) begin
         @(negedge clk);
         check({"R5 tail data ", tag}, tx_data, 1);
         check({"R5 tail oe ", tag}, tx_oe, 1);
      end
      @(negedge clk);
      check({"R5 released oe ", tag}, tx_oe, 0);
      check({"R5 released data ", tag}, tx_data, 0);
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int highs;
      int first;
      repeat (3) @(negedge clk);
      check("R1 reset oe", tx_oe, 0);
      check("R1 reset data", tx_data, 0);
      check("R1 reset jabber", jabber, 0);
      rst_n = 1'b1;

      // R6: link pulses from reset release
      highs = 0;
      first = -1;
      for (int k = 1; k <= 2 * LINKP; k++) begin
         @(negedge clk);
         if (tx_oe) begin
            highs++;
            if (first < 0) first = k;
         end
         if (tx_data !== tx_oe) check("R6 pulse data follows oe", tx_data, tx_oe);
         if (k == 1) check("R1 jabber after reset", jabber, 0);
      end
      check("R6 pulse clocks", highs, 2 * 2 * HALF);
      check("R6 first pulse clock", first, LINKP - 2 * HALF);

      // R2 R3 R4 R5: table of frames, expected symbols computed per bit
      for (int f = 0; f < NFR; f++) run_frame(FRAMES[f], 4, "table");
      run_frame(16'h0009, 1, "single");

      // R7: jabber entry
      wait_strobe();
      mii_txd   = 4'h5;
      mii_tx_en = 1'b1;
      for (int k = 1; k <= 250; k++) begin
         @(negedge clk);
         if (k == JABC - 1) begin
            check("R7 jabber before limit", jabber, 0);
            check("R7 oe before limit", tx_oe, 1);
         end
         if (k == JABC) check("R7 jabber at limit", jabber, 1);
         if (k >= JABC) begin
            check("R7 R8 oe off in lockout", tx_oe, 0);
            check("R8 data low in lockout", tx_data, 0);
         end
      end
      // R8 R9: idle broken once, then a full idle run
      mii_tx_en = 1'b0;
      for (int m = 1; m <= 150; m++) begin
         @(negedge clk);
         check("R8 no link pulse in lockout", tx_oe, 0);
      end
      mii_tx_en = 1'b1;
      @(negedge clk);
      check("R8 enable ignored in lockout", tx_oe, 0);
      mii_tx_en = 1'b0;
      for (int n = 1; n <= UNJC; n++) begin
         @(negedge clk);
         if (n == UNJC - 1) check("R9 still locked", jabber, 1);
         if (n == UNJC) check("R9 lockout released", jabber, 0);
         if (n < UNJC) check("R8 oe off awaiting release", tx_oe, 0);
      end

      // R10: normal transmission resumes
      run_frame(16'hC3A5, 4, "R10 resume");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule